// File: doc/BRIEF.md
# Coalescing Write Buffer with Read Forwarding

The block is a small store queue between a processor and a slow memory port. Processor writes are accepted into an eight-slot circular queue in a single cycle. The memory side never delays them. The queue drains toward memory one entry at a time over a valid/ready write channel, oldest first.

A write whose address already sits in a queued entry that memory is not yet looking at overwrites that entry's data in place. The oldest entry, which is on offer to memory, is frozen. A matching write therefore opens a fresh slot behind it.

Processor reads are compared against every queued entry. When a read matches, the youngest matching entry answers one cycle later. When a read misses, it goes out on a separate memory read channel. This can happen ahead of older queued writes to other addresses. A read miss is launched only in a cycle in which no write beat is transferring. While a read is being served, the processor write port is held off, so a later write cannot overtake it on its way to memory.

Top module: `wrbuf_coalesce`

## Requirements
- R1: A synchronous active-low reset discards every queued write. After reset, `mem_wr_valid` and `rd_resp_valid` are low, and `wr_ready` is high when no read is in progress.
- R2: Queued writes appear on the memory write channel in the order they were accepted, one beat per `mem_wr_valid`/`mem_wr_ready` handshake.
- R3: A write to an address held in a queued entry other than the oldest one replaces that entry's data without using a new slot.
- R4: The oldest entry is on offer to memory whenever `mem_wr_valid` is high. Its address and data stay stable until the handshake, and it cannot be merged into. A write to its address takes a new slot, and both beats reach memory.
- R5: A read whose address matches queued entries returns the data of the youngest match, with `rd_resp_valid` high in the cycle after the read is accepted.
- R6: A read that matches no entry is issued on `mem_rd_valid`/`mem_rd_addr`. The memory answer comes back on `rd_resp_data` with a one-cycle `rd_resp_valid` pulse, one cycle after `mem_rd_resp_valid`. No new read is accepted while `rd_resp_valid` is high.
- R7: The queue holds DEPTH (default 8) entries. When it is full, `wr_ready` is low for a write that matches no mergeable entry, and high for a write that matches a non-oldest entry.
- R8: Accepting a write never waits on memory. With free space or a mergeable match, and no read pending, `wr_ready` is high even while `mem_wr_ready` is low.
- R9: A read takes precedence. `wr_ready` is low while `rd_valid` is high, and low from the acceptance of a read miss until its response.
- R10: `mem_rd_valid` is never high in a cycle in which a write beat is handed to memory.
- R11: A new slot allocated in the same cycle as a drain handshake leaves the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Processor write request |
| wr_ready | output | 1 | Write accepted in this cycle when high with `wr_valid` |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_valid | input | 1 | Processor read request |
| rd_ready | output | 1 | Read accepted when high with `rd_valid` |
| rd_addr | input | ADDR_W | Read address |
| rd_resp_valid | output | 1 | One-cycle read response strobe |
| rd_resp_data | output | DATA_W | Read response data |
| mem_wr_valid | output | 1 | Oldest queued write on offer to memory |
| mem_wr_ready | input | 1 | Memory takes the offered write |
| mem_wr_addr | output | ADDR_W | Address of offered write |
| mem_wr_data | output | DATA_W | Data of offered write |
| mem_rd_valid | output | 1 | Read-miss request to memory |
| mem_rd_ready | input | 1 | Memory takes the read request |
| mem_rd_addr | output | ADDR_W | Read-miss address |
| mem_rd_resp_valid | input | 1 | Memory read data strobe |
| mem_rd_resp_data | input | DATA_W | Memory read data |

## Verification
The properties take for granted a processor that keeps a request's address and data steady until it is accepted. They also assume a memory that returns exactly one read answer for each accepted read request, and never in the cycle of that request. The stimulus changes inputs only on falling edges and issues one read at a time. The bench memory model answers every read request two cycles later. It drops `mem_wr_ready` for whole stretches to build up queue contents, which keeps every checked case inside those assumptions.

// File: rtl/wrbuf_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the coalescing write buffer.
// Assumes nothing beyond standard SystemVerilog packages.
package wrbuf_pkg;

    // Read-path sequencing states
    typedef enum logic [1:0] {
        RD_IDLE  = 2'd0,
        RD_ISSUE = 2'd1,
        RD_WAIT  = 2'd2
    } rd_state_e;

endpackage

// File: rtl/wrbuf_store.sv
`timescale 1ns/1ps
// Circular entry store for the write buffer.
// Holds DEPTH queued writes, merges new writes into matching younger
// entries, offers the oldest entry to memory and finds the youngest
// entry matching a read address.
// Assumes DEPTH is a power of two, at least 2, and that wr_fire is never
// raised for an allocating write while full is high.
module wrbuf_store #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_fire,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic                         pop,
    input  logic [ADDR_W-1:0]            lk_addr,
    output logic                         merge_hit,
    output logic                         push_alloc,
    output logic                         full,
    output logic                         head_valid,
    output logic [ADDR_W-1:0]            head_addr,
    output logic [DATA_W-1:0]            head_data,
    output logic                         lk_hit,
    output logic [DATA_W-1:0]            lk_data,
    output logic [$clog2(DEPTH+1)-1:0]   occ
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [DEPTH-1:0]  ent_vld;
    logic [ADDR_W-1:0] ent_addr [DEPTH];
    logic [DATA_W-1:0] ent_data [DEPTH];
    logic [PTR_W-1:0]  head_ptr;
    logic [PTR_W-1:0]  tail_ptr;
    logic [PTR_W-1:0]  merge_idx;
    logic [PTR_W-1:0]  lk_idx;
    logic [DEPTH-1:0]  merge_vec;
    logic [DEPTH-1:0]  lk_vec;
    logic [CNT_W-1:0]  occ_q;

    // Per-slot address comparators for merging and for read lookup
    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
            localparam logic [PTR_W-1:0] SLOT = PTR_W'(g);
            assign merge_vec[g] = ent_vld[g] && (ent_addr[g] == wr_addr)
                                  && (SLOT != head_ptr);
            assign lk_vec[g]    = ent_vld[g] && (ent_addr[g] == lk_addr);
        end
    endgenerate

    // Encode the (unique) mergeable slot
    always_comb begin
        merge_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (merge_vec[i]) merge_idx = PTR_W'(i);
        end
    end

    // Pick the matching slot furthest from the head, i.e. the youngest
    always_comb begin
        logic [PTR_W-1:0] age_i;
        logic [PTR_W-1:0] best_age;
        logic             found;
        lk_idx   = '0;
        best_age = '0;
        found    = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            age_i = PTR_W'(i) - head_ptr;
            if (lk_vec[i] && (!found || age_i > best_age)) begin
                found    = 1'b1;
                best_age = age_i;
                lk_idx   = PTR_W'(i);
            end
        end
    end

    assign merge_hit  = |merge_vec;
    assign push_alloc = wr_fire && !merge_hit;
    assign full       = (occ_q == CNT_W'(DEPTH));
    assign head_valid = (occ_q != '0);
    assign head_addr  = ent_addr[head_ptr];
    assign head_data  = ent_data[head_ptr];
    assign lk_hit     = |lk_vec;
    assign lk_data    = ent_data[lk_idx];
    assign occ        = occ_q;

    // Slot valid bits, pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_vld  <= '0;
            head_ptr <= '0;
            tail_ptr <= '0;
            occ_q    <= '0;
        end else begin
            if (pop) begin
                ent_vld[head_ptr] <= 1'b0;
                head_ptr          <= head_ptr + 1'b1;
            end
            if (push_alloc) begin
                ent_vld[tail_ptr] <= 1'b1;
                tail_ptr          <= tail_ptr + 1'b1;
            end
            case ({push_alloc, pop})
                2'b10:   occ_q <= occ_q + 1'b1;
                2'b01:   occ_q <= occ_q - 1'b1;
                default: occ_q <= occ_q;
            endcase
        end
    end

    // Slot payload: fill on allocation, overwrite data on merge
    always_ff @(posedge clk) begin
        if (push_alloc) begin
            ent_addr[tail_ptr] <= wr_addr;
            ent_data[tail_ptr] <= wr_data;
        end else if (wr_fire && merge_hit) begin
            ent_data[merge_idx] <= wr_data;
        end
    end

endmodule

// File: rtl/wrbuf_read_ctl.sv
`timescale 1ns/1ps
// Read path of the write buffer.
// Serves a read from the entry store on a hit, otherwise issues it on the
// memory read channel in a cycle without a write beat, then returns the
// answer as a one-cycle response pulse.
// Assumes memory answers each accepted read once, in a later cycle.
module wrbuf_read_ctl
    import wrbuf_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_ready,
    output logic              rd_resp_valid,
    output logic [DATA_W-1:0] rd_resp_data,
    input  logic              lk_hit,
    input  logic [DATA_W-1:0] lk_data,
    input  logic              mem_wr_busy,
    output logic              mem_rd_valid,
    input  logic              mem_rd_ready,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_resp_valid,
    input  logic [DATA_W-1:0] mem_rd_resp_data,
    output logic              rd_busy
);
    rd_state_e         state_q;
    logic [ADDR_W-1:0] miss_addr_q;

    // Handshake outputs derived from the current state
    always_comb begin
        rd_ready     = (state_q == RD_IDLE) && !rd_resp_valid;
        mem_rd_valid = (state_q == RD_ISSUE) && !mem_wr_busy;
    end

    assign mem_rd_addr = miss_addr_q;
    assign rd_busy     = (state_q != RD_IDLE);

    // Read sequencing and response registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= RD_IDLE;
            rd_resp_valid <= 1'b0;
            rd_resp_data  <= '0;
            miss_addr_q   <= '0;
        end else begin
            rd_resp_valid <= 1'b0;
            case (state_q)
                RD_IDLE: begin
                    if (rd_valid && rd_ready) begin
                        if (lk_hit) begin
                            rd_resp_valid <= 1'b1;
                            rd_resp_data  <= lk_data;
                        end else begin
                            miss_addr_q <= rd_addr;
                            state_q     <= RD_ISSUE;
                        end
                    end
                end
                RD_ISSUE: begin
                    if (mem_rd_valid && mem_rd_ready) state_q <= RD_WAIT;
                end
                RD_WAIT: begin
                    if (mem_rd_resp_valid) begin
                        rd_resp_valid <= 1'b1;
                        rd_resp_data  <= mem_rd_resp_data;
                        state_q       <= RD_IDLE;
                    end
                end
                default: state_q <= RD_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/wrbuf_coalesce.sv
`timescale 1ns/1ps
// Coalescing write buffer with read forwarding.
// Accepts processor writes into a merging queue, drains them to memory in
// acceptance order, and answers reads from the queue or from memory.
// Assumes requesters hold address and data steady until accepted.
module wrbuf_coalesce #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_valid,
    output logic              rd_ready,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_resp_valid,
    output logic [DATA_W-1:0] rd_resp_data,
    output logic              mem_wr_valid,
    input  logic              mem_wr_ready,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data,
    output logic              mem_rd_valid,
    input  logic              mem_rd_ready,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_resp_valid,
    input  logic [DATA_W-1:0] mem_rd_resp_data
);
    localparam int CNT_W = $clog2(DEPTH+1);

    logic              wr_fire;
    logic              pop;
    logic              merge_hit;
    logic              push_alloc;
    logic              full;
    logic              lk_hit;
    logic [DATA_W-1:0] lk_data;
    logic [CNT_W-1:0]  occ;
    logic              rd_busy;

    // Write admission: reads first, then room or a merge target
    assign wr_ready = !rd_valid && !rd_busy && (merge_hit || !full);
    assign wr_fire  = wr_valid && wr_ready;
    assign pop      = mem_wr_valid && mem_wr_ready;

    wrbuf_store #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) store_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_fire    (wr_fire),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .pop        (pop),
        .lk_addr    (rd_addr),
        .merge_hit  (merge_hit),
        .push_alloc (push_alloc),
        .full       (full),
        .head_valid (mem_wr_valid),
        .head_addr  (mem_wr_addr),
        .head_data  (mem_wr_data),
        .lk_hit     (lk_hit),
        .lk_data    (lk_data),
        .occ        (occ)
    );

    wrbuf_read_ctl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) rdctl_i (
        .clk               (clk),
        .rst_n             (rst_n),
        .rd_valid          (rd_valid),
        .rd_addr           (rd_addr),
        .rd_ready          (rd_ready),
        .rd_resp_valid     (rd_resp_valid),
        .rd_resp_data      (rd_resp_data),
        .lk_hit            (lk_hit),
        .lk_data           (lk_data),
        .mem_wr_busy       (pop),
        .mem_rd_valid      (mem_rd_valid),
        .mem_rd_ready      (mem_rd_ready),
        .mem_rd_addr       (mem_rd_addr),
        .mem_rd_resp_valid (mem_rd_resp_valid),
        .mem_rd_resp_data  (mem_rd_resp_data),
        .rd_busy           (rd_busy)
    );

endmodule

// File: rtl/wrbuf_checker.sv
`timescale 1ns/1ps
// Property checker for wrbuf_coalesce, attached by bind.
// Assumes a processor that holds requests until accepted.
module wrbuf_checker #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wr_ready,
    input logic                       rd_valid,
    input logic                       rd_busy,
    input logic                       rd_resp_valid,
    input logic                       mem_wr_valid,
    input logic                       mem_wr_ready,
    input logic [ADDR_W-1:0]          mem_wr_addr,
    input logic [DATA_W-1:0]          mem_wr_data,
    input logic                       mem_rd_valid,
    input logic [$clog2(DEPTH+1)-1:0] occ,
    input logic                       merge_hit,
    input logic                       push_alloc,
    input logic                       pop
);
    localparam int CNT_W = $clog2(DEPTH+1);

    // R4: an offered head entry is frozen until memory takes it
    assert_head_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_valid && !mem_wr_ready) |=>
        (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

    // R7: occupancy never exceeds the slot count
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CNT_W'(DEPTH));

    // R7: full queue refuses a write that has no merge target
    assert_full_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == CNT_W'(DEPTH) && !merge_hit) |-> !wr_ready);

    // R9: pending reads hold off writes
    assert_rd_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid || rd_busy) |-> !wr_ready);

    // R10: read misses avoid write-beat cycles
    assert_rd_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> !(mem_wr_valid && mem_wr_ready));

    // R11: allocate plus drain keeps occupancy
    assert_occ_steady_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (push_alloc && pop) |=> (occ == $past(occ)));

    // R6: responses are single-cycle pulses
    assert_resp_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_resp_valid |=> !rd_resp_valid);

    // R8: an empty queue with no read pending takes a write
    assert_empty_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_wr_valid && !rd_valid && !rd_busy) |-> wr_ready);

endmodule

bind wrbuf_coalesce wrbuf_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_ready      (wr_ready),
    .rd_valid      (rd_valid),
    .rd_busy       (rd_busy),
    .rd_resp_valid (rd_resp_valid),
    .mem_wr_valid  (mem_wr_valid),
    .mem_wr_ready  (mem_wr_ready),
    .mem_wr_addr   (mem_wr_addr),
    .mem_wr_data   (mem_wr_data),
    .mem_rd_valid  (mem_rd_valid),
    .occ           (occ),
    .merge_hit     (merge_hit),
    .push_alloc    (push_alloc),
    .pop           (pop)
);

// File: tb/wrbuf_coalesce_tb.sv
`timescale 1ns/1ps
// Self-checking bench for wrbuf_coalesce.
module wrbuf_coalesce_tb_top;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam int NV = 12;

    // Vector table: read flag, address, write data or expected read data
    localparam bit        VEC_RD   [NV] = '{1, 0, 1, 0, 0, 1, 1, 0, 1, 0, 1, 1};
    localparam logic [7:0] VEC_ADDR [NV] = '{8'h10, 8'h10, 8'h10, 8'h20, 8'h10, 8'h10,
                                            8'h20, 8'h30, 8'h31, 8'h30, 8'h30, 8'h40};
    localparam logic [31:0] VEC_DATA [NV] = '{32'hC0DE0010, 32'h11111111, 32'h11111111,
                                             32'h22222222, 32'h33333333, 32'h33333333,
                                             32'h22222222, 32'h44444444, 32'hC0DE0031,
                                             32'h55555555, 32'h55555555, 32'hC0DE0040};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_valid = 1'b0;
    logic          wr_ready;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_valid = 1'b0;
    logic          rd_ready;
    logic [AW-1:0] rd_addr = '0;
    logic          rd_resp_valid;
    logic [DW-1:0] rd_resp_data;
    logic          mem_wr_valid;
    logic          mem_wr_ready;
    logic [AW-1:0] mem_wr_addr;
    logic [DW-1:0] mem_wr_data;
    logic          mem_rd_valid;
    logic          mem_rd_ready;
    logic [AW-1:0] mem_rd_addr;
    logic          mem_rd_resp_valid = 1'b0;
    logic [DW-1:0] mem_rd_resp_data = '0;

    logic          mem_wr_en = 1'b1;
    int            checks = 0;
    int            errors = 0;

    // Memory model state
    logic [DW-1:0] mem_arr [256];
    bit            mem_loaded = 1'b0;
    logic [7:0]    log_addr [256];
    logic [31:0]   log_data [256];
    int            log_n = 0;
    int            gap_err = 0;
    int            rd_cnt = 0;
    logic [AW-1:0] rd_a = '0;

    assign mem_wr_ready = mem_wr_en;
    assign mem_rd_ready = 1'b1;

    always #4 clk = ~clk;

    wrbuf_coalesce #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(8)) dut_i (
        .clk               (clk),
        .rst_n             (rst_n),
        .wr_valid          (wr_valid),
        .wr_ready          (wr_ready),
        .wr_addr           (wr_addr),
        .wr_data           (wr_data),
        .rd_valid          (rd_valid),
        .rd_ready          (rd_ready),
        .rd_addr           (rd_addr),
        .rd_resp_valid     (rd_resp_valid),
        .rd_resp_data      (rd_resp_data),
        .mem_wr_valid      (mem_wr_valid),
        .mem_wr_ready      (mem_wr_ready),
        .mem_wr_addr       (mem_wr_addr),
        .mem_wr_data       (mem_wr_data),
        .mem_rd_valid      (mem_rd_valid),
        .mem_rd_ready      (mem_rd_ready),
        .mem_rd_addr       (mem_rd_addr),
        .mem_rd_resp_valid (mem_rd_resp_valid),
        .mem_rd_resp_data  (mem_rd_resp_data)
    );

    // Memory model: logs write beats, answers reads two cycles later
    always @(posedge clk) begin
        if (!mem_loaded) begin
            for (int a = 0; a < 256; a++) mem_arr[a] <= 32'hC0DE0000 | 32'(a);
            mem_loaded <= 1'b1;
        end else if (mem_wr_valid && mem_wr_ready) begin
            mem_arr[mem_wr_addr] <= mem_wr_data;
        end
        if (mem_wr_valid && mem_wr_ready) begin
            log_addr[log_n[7:0]] <= mem_wr_addr;
            log_data[log_n[7:0]] <= mem_wr_data;
            log_n <= log_n + 1;
        end
        if (mem_rd_valid && mem_wr_valid && mem_wr_ready) gap_err <= gap_err + 1;
        mem_rd_resp_valid <= 1'b0;
        if (rd_cnt == 1) begin
            mem_rd_resp_valid <= 1'b1;
            mem_rd_resp_data  <= mem_arr[rd_a];
        end
        if (rd_cnt != 0) rd_cnt <= rd_cnt - 1;
        if (mem_rd_valid && mem_rd_ready) begin
            rd_cnt <= 2;
            rd_a   <= mem_rd_addr;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d, output int waits);
        waits = 0;
        @(negedge clk);
        wr_valid = 1'b1;
        wr_addr  = a;
        wr_data  = d;
        #1;
        while (!wr_ready && waits < 500) begin
            waits++;
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        wr_valid = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] a, output logic [31:0] d, output int lat);
        int guard = 0;
        @(negedge clk);
        rd_valid = 1'b1;
        rd_addr  = a;
        #1;
        while (!rd_ready && guard < 500) begin
            guard++;
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        rd_valid = 1'b0;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!rd_resp_valid && lat < 200);
        d = rd_resp_data;
    endtask

    task automatic wait_drain();
        int guard = 0;
        @(negedge clk);
        while (mem_wr_valid && guard < 300) begin
            guard++;
            @(negedge clk);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        summary();
        $finish;
    end

    initial begin
        int w;
        int lat;
        int base;
        logic [31:0] d;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: state out of reset
        check(mem_wr_valid == 1'b0, "R1 mem_wr_valid after reset", 32'(mem_wr_valid), 32'd0);
        check(wr_ready == 1'b1, "R1 wr_ready after reset", 32'(wr_ready), 32'd1);
        check(rd_resp_valid == 1'b0, "R1 rd_resp_valid after reset", 32'(rd_resp_valid), 32'd0);

        // Table walk: reads must always see the latest written value (R5 R6)
        for (int k = 0; k < NV; k++) begin
            if (VEC_RD[k]) begin
                do_read(VEC_ADDR[k], d, lat);
                check(d == VEC_DATA[k], $sformatf("R5 R6 vector %0d read", k), d, VEC_DATA[k]);
            end else begin
                do_write(VEC_ADDR[k], VEC_DATA[k], w);
            end
        end
        wait_drain();

        // Merge, head lock, newest forward, order (R2 R3 R4 R5 R8)
        mem_wr_en = 1'b0;
        base = log_n;
        do_write(8'h50, 32'hA1A1A1A1, w);
        do_write(8'h51, 32'hA2A2A2A2, w);
        do_write(8'h52, 32'hA3A3A3A3, w);
        do_write(8'h51, 32'hB2B2B2B2, w);
        do_write(8'h50, 32'hB1B1B1B1, w);
        check(w == 0, "R8 write accepted while memory stalled", 32'(w), 32'd0);
        do_read(8'h50, d, lat);
        check(d == 32'hB1B1B1B1, "R5 newest match forwarded", d, 32'hB1B1B1B1);
        check(lat == 1, "R5 hit latency", 32'(lat), 32'd1);
        do_read(8'h51, d, lat);
        check(d == 32'hB2B2B2B2, "R3 merged data forwarded", d, 32'hB2B2B2B2);
        @(negedge clk);
        mem_wr_en = 1'b1;
        wait_drain();
        check(log_n - base == 4, "R3 beats after merge", 32'(log_n - base), 32'd4);
        check(log_addr[8'(base)] == 8'h50 && log_data[8'(base)] == 32'hA1A1A1A1,
              "R2 first beat", log_data[8'(base)], 32'hA1A1A1A1);
        check(log_addr[8'(base+1)] == 8'h51 && log_data[8'(base+1)] == 32'hB2B2B2B2,
              "R2 second beat", log_data[8'(base+1)], 32'hB2B2B2B2);
        check(log_addr[8'(base+2)] == 8'h52, "R2 third beat", 32'(log_addr[8'(base+2)]), 32'h52);
        check(log_addr[8'(base+3)] == 8'h50 && log_data[8'(base+3)] == 32'hB1B1B1B1,
              "R4 locked head gave new slot", log_data[8'(base+3)], 32'hB1B1B1B1);
        check(mem_arr[8'h50] == 32'hB1B1B1B1, "R4 final memory value", mem_arr[8'h50], 32'hB1B1B1B1);

        // Reset discards queued writes (R1)
        mem_wr_en = 1'b0;
        do_write(8'h58, 32'h1, w);
        do_write(8'h59, 32'h2, w);
        do_reset();
        mem_wr_en = 1'b1;
        base = log_n;
        #1;
        check(mem_wr_valid == 1'b0, "R1 queue empty after reset", 32'(mem_wr_valid), 32'd0);
        repeat (3) @(negedge clk);
        check(log_n == base, "R1 no beats after reset", 32'(log_n - base), 32'd0);

        // Capacity (R7 R8)
        mem_wr_en = 1'b0;
        base = log_n;
        for (int k = 0; k < 8; k++) begin
            do_write(8'h60 + 8'(k), 32'h600 + 32'(k), w);
            check(w == 0, "R8 accept without memory", 32'(w), 32'd0);
        end
        @(negedge clk);
        wr_valid = 1'b1;
        wr_addr  = 8'h70;
        #1;
        check(wr_ready == 1'b0, "R7 full refuses new address", 32'(wr_ready), 32'd0);
        wr_addr = 8'h60;
        #1;
        check(wr_ready == 1'b0, "R4 R7 full refuses locked head", 32'(wr_ready), 32'd0);
        wr_addr = 8'h62;
        #1;
        check(wr_ready == 1'b1, "R7 full accepts merge", 32'(wr_ready), 32'd1);
        wr_valid = 1'b0;
        do_write(8'h62, 32'h0000BEEF, w);
        check(w == 0, "R7 merge while full", 32'(w), 32'd0);
        mem_wr_en = 1'b1;
        wait_drain();
        check(log_n - base == 8, "R7 beats after full", 32'(log_n - base), 32'd8);
        check(mem_arr[8'h62] == 32'h0000BEEF, "R7 merged value in memory", mem_arr[8'h62], 32'h0000BEEF);

        // Allocate plus drain in one cycle (R11)
        do_reset();
        mem_wr_en = 1'b0;
        base = log_n;
        for (int k = 0; k < 7; k++) do_write(8'h80 + 8'(k), 32'h800 + 32'(k), w);
        @(negedge clk);
        mem_wr_en = 1'b1;
        wr_valid  = 1'b1;
        wr_addr   = 8'h87;
        wr_data   = 32'h887;
        #1;
        check(wr_ready == 1'b1, "R11 accept with one slot free", 32'(wr_ready), 32'd1);
        @(posedge clk);
        #1;
        mem_wr_en = 1'b0;
        wr_valid  = 1'b0;
        do_write(8'h88, 32'h888, w);
        check(w == 0, "R11 slot freed by drain", 32'(w), 32'd0);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_addr  = 8'h89;
        #1;
        check(wr_ready == 1'b0, "R11 full again", 32'(wr_ready), 32'd0);
        wr_valid = 1'b0;
        mem_wr_en = 1'b1;
        wait_drain();
        check(log_n - base == 9, "R11 total beats", 32'(log_n - base), 32'd9);

        // Read precedence and miss path (R9 R6)
        @(negedge clk);
        rd_valid = 1'b1;
        rd_addr  = 8'h90;
        wr_valid = 1'b1;
        wr_addr  = 8'h91;
        #1;
        check(wr_ready == 1'b0, "R9 read holds off write", 32'(wr_ready), 32'd0);
        check(rd_ready == 1'b1, "R9 read accepted", 32'(rd_ready), 32'd1);
        @(posedge clk);
        #1;
        rd_valid = 1'b0;
        @(negedge clk);
        #1;
        check(wr_ready == 1'b0, "R9 write held during miss", 32'(wr_ready), 32'd0);
        wr_valid = 1'b0;
        lat = 0;
        while (!rd_resp_valid && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        check(rd_resp_data == 32'hC0DE0090, "R6 miss data from memory", rd_resp_data, 32'hC0DE0090);
        @(negedge clk);
        check(rd_resp_valid == 1'b0, "R6 response is a pulse", 32'(rd_resp_valid), 32'd0);

        // Read miss waits for write beats to clear (R10)
        mem_wr_en = 1'b0;
        base = log_n;
        for (int k = 0; k < 4; k++) do_write(8'hB0 + 8'(k), 32'hB00 + 32'(k), w);
        mem_wr_en = 1'b1;
        do_read(8'hA0, d, lat);
        check(d == 32'hC0DE00A0, "R10 miss data", d, 32'hC0DE00A0);
        check(log_n - base == 4, "R10 read issued after write beats", 32'(log_n - base), 32'd4);
        check(gap_err == 0, "R10 no read during write beat", 32'(gap_err), 32'd0);

        summary();
        $finish;
    end

endmodule